// File: doc/BRIEF.md
# Calibration Parameter and Temperature Result Serial Port

This block is the serial slave port of an on-chip temperature sensor. An external master uses it for two things: to load the three calibration coefficients that the temperature calculator uses, and to read back the result of the most recent conversion. That result is the calibrated temperature word followed by the two raw integration counts. The port works in SPI mode 0: the clock idles low, the master samples on the rising edge and the slave changes its output on the falling edge. Every field travels most significant bit first.

Each frame framed by chip select carries both directions at the same time. The first 24 bits on the master-out line form a write word: an 8-bit command and then a 16-bit coefficient. At the same time the slave returns a 44-bit result frame on the master-in line. That frame is a snapshot held in the system clock domain. The snapshot is refreshed by a conversion-done pulse only while chip select is idle, so a read in progress always sees one consistent result.

A write that completes crosses into the system clock through a two-flop synchronized toggle and is parked in a pending register. The calibration outputs take the pending value only on a conversion-start pulse, so one conversion always runs with one consistent set of coefficients.

Top module: `spi_cal_port`

## Requirements
- R1: After a synchronous reset, the coefficient outputs hold their defaults: cal_a0 = 0x4D50 (0.302 with 16 fractional bits), cal_a1 = 0x0FF9 (0.0039 with 20 fractional bits), cal_ftrim = 0x4894 (1.134 with 14 fractional bits).
- R2: A frame of at least 24 clocks writes a coefficient. The first 8 bits are the command and bits 9 to 24 are the value, both MSB first. Command 0x01 selects cal_a0, 0x02 selects cal_a1 and 0x03 selects cal_ftrim. Bits after the 24th are ignored.
- R3: A command other than 0x01, 0x02 or 0x03 changes no coefficient output, including after later conversion starts.
- R4: A written value does not appear on its output before the next conv_start pulse. It appears in the cycle after conv_start is sampled high, and the outputs hold their value in every cycle in which conv_start was low.
- R5: A frame in which chip select rises before the 24th clock writes nothing.
- R6: The read frame is 44 bits: temp_in (12 bits, two's complement with 4 fractional bits), then cnt_ptat (16 bits), then cnt_ctat (16 bits), each MSB first. The first bit is valid after chip select falls, and each following bit is presented after a falling clock edge.
- R7: conv_done latches {temp_in, cnt_ptat, cnt_ctat} into the read snapshot only when chip select has been high for at least two system clocks. A conv_done pulse during a transfer is dropped: both that transfer and the next one return the earlier snapshot.
- R8: spi_miso is high impedance while chip select is high. Clocks beyond the 44th bit of a frame return 0.
- R9: A frame that reads the snapshot also performs the write carried in its first 24 bits. A read with the master-out line held low (command 0x00) writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| conv_start | input | 1 | One-cycle pulse at the start of a conversion; applies pending coefficients |
| conv_done | input | 1 | One-cycle pulse when a new result is valid |
| temp_in | input | 12 | Calibrated temperature, two's complement, 4 fractional bits |
| cnt_ptat | input | 16 | Raw count of the rising-current integration phase |
| cnt_ctat | input | 16 | Raw count of the falling-current integration phase |
| cal_a0 | output | 16 | Offset coefficient |
| cal_a1 | output | 16 | Slope coefficient |
| cal_ftrim | output | 16 | Current-ratio trim coefficient |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, high impedance when deselected |

## Verification
In every system clock cycle the assertions check the reset defaults of the coefficients, that the coefficients stay unchanged unless conv_start was high, that the snapshot stays frozen while chip select is seen as active, and that an idle conv_done copies exactly the three result inputs. The command decode and its ignored codes, the short-frame rule, the bit order and tail zeros on the serial output, the high-impedance idle line, and the dropping of a conv_done pulse during a transfer span both clock domains. Only the bench's transfer scenarios can show them, by comparing what the master shifts in and what appears on the coefficient outputs against a model.

// File: rtl/spi_cal_pkg.sv
package spi_cal_pkg;
  // Number of programmable coefficients; command code = CMD_BASE + index
  localparam int NUM_COEF = 3;
  localparam logic [7:0] CMD_BASE = 8'h01;
  typedef enum int {IDX_A0 = 0, IDX_A1 = 1, IDX_FTRIM = 2} coef_idx_e;
endpackage

// File: rtl/spi_cal_wr_rx.sv
// Serial-clock domain: collects the first FRAME_W bits of a frame and
// flags completion with a toggle.
module spi_cal_wr_rx #(
  parameter int FRAME_W = 24
) (
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic [FRAME_W-1:0] wr_word,
  output logic               wr_tgl
);
  localparam int CW = $clog2(FRAME_W + 1);

  logic [CW-1:0]      bit_cnt;
  logic [FRAME_W-2:0] shreg;

  always_ff @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n)                     bit_cnt <= '0;
    else if (bit_cnt != CW'(FRAME_W)) bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(posedge spi_sclk) begin
    if (bit_cnt != CW'(FRAME_W)) shreg <= {shreg[FRAME_W-3:0], spi_mosi};
    if (bit_cnt == CW'(FRAME_W - 1)) begin
      wr_word <= {shreg, spi_mosi};
      wr_tgl  <= ~wr_tgl;
    end
  end
endmodule

// File: rtl/spi_cal_tgl_sync.sv
// System domain: two-flop synchronizer on the write toggle, edge detect,
// then captures the (stable) write word.
module spi_cal_tgl_sync #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tgl_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              stb,
  output logic [DATA_W-1:0] data_out
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    s1 <= tgl_in;
    s2 <= s1;
    if (rst) begin
      s3  <= s2;   // rebase: no event for whatever the toggle holds at reset
      stb <= 1'b0;
    end else begin
      s3  <= s2;
      stb <= s2 ^ s3;
      if (s2 ^ s3) data_out <= data_in;
    end
  end
endmodule

// File: rtl/spi_cal_param_bank.sv
// Pending and active coefficient registers; decode on write strobe,
// transfer pending->active on conversion start.
module spi_cal_param_bank
  import spi_cal_pkg::*;
#(
  parameter int                CMD_W   = 8,
  parameter int                PARAM_W = 16,
  parameter logic [PARAM_W-1:0] A0_DEF = 16'h4D50,
  parameter logic [PARAM_W-1:0] A1_DEF = 16'h0FF9,
  parameter logic [PARAM_W-1:0] FT_DEF = 16'h4894
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_stb,
  input  logic [CMD_W+PARAM_W-1:0] wr_data,
  input  logic                     conv_start,
  output logic [PARAM_W-1:0]       coef_q [NUM_COEF]
);
  logic [CMD_W-1:0]   cmd;
  logic [PARAM_W-1:0] val;
  assign cmd = wr_data[CMD_W+PARAM_W-1 -: CMD_W];
  assign val = wr_data[PARAM_W-1:0];

  for (genvar g = 0; g < NUM_COEF; g++) begin : g_coef
    localparam logic [PARAM_W-1:0] DEF =
      (g == IDX_A0) ? A0_DEF : (g == IDX_A1) ? A1_DEF : FT_DEF;
    localparam logic [CMD_W-1:0] CODE = CMD_W'(CMD_BASE) + CMD_W'(g);
    logic [PARAM_W-1:0] pend;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend      <= DEF;
        coef_q[g] <= DEF;
      end else begin
        if (wr_stb && cmd == CODE) pend <= val;
        if (conv_start)            coef_q[g] <= pend;
      end
    end
  end
endmodule

// File: rtl/spi_cal_rd_tx.sv
// Result snapshot (system domain) and serial output bit select
// (serial-clock domain, advances on falling edges).
module spi_cal_rd_tx #(
  parameter int TOT_W = 44
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic [TOT_W-1:0] res_word,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  output logic             tx_bit,
  output logic             cs_idle,
  output logic [TOT_W-1:0] rd_frame
);
  localparam int IW = $clog2(TOT_W + 1);

  logic          cs_m;
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_m     <= 1'b1;
      cs_idle  <= 1'b1;
      rd_frame <= '0;
    end else begin
      cs_m    <= spi_cs_n;
      cs_idle <= cs_m;
      if (conv_done && cs_idle) rd_frame <= res_word;
    end
  end

  always_ff @(negedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n)                idx <= '0;
    else if (idx != IW'(TOT_W))  idx <= idx + 1'b1;
  end

  always_comb begin
    if (idx < IW'(TOT_W)) tx_bit = rd_frame[IW'(TOT_W - 1) - idx];
    else                  tx_bit = 1'b0;
  end
endmodule

// File: rtl/spi_cal_port.sv
module spi_cal_port
  import spi_cal_pkg::*;
#(
  parameter int                 TEMP_W  = 12,
  parameter int                 CNT_W   = 16,
  parameter int                 CMD_W   = 8,
  parameter int                 PARAM_W = 16,
  parameter logic [PARAM_W-1:0] A0_DEF  = 16'h4D50,
  parameter logic [PARAM_W-1:0] A1_DEF  = 16'h0FF9,
  parameter logic [PARAM_W-1:0] FT_DEF  = 16'h4894
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               conv_start,
  input  logic               conv_done,
  input  logic [TEMP_W-1:0]  temp_in,
  input  logic [CNT_W-1:0]   cnt_ptat,
  input  logic [CNT_W-1:0]   cnt_ctat,
  output logic [PARAM_W-1:0] cal_a0,
  output logic [PARAM_W-1:0] cal_a1,
  output logic [PARAM_W-1:0] cal_ftrim,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso
);
  localparam int WR_W  = CMD_W + PARAM_W;
  localparam int TOT_W = TEMP_W + 2 * CNT_W;

  logic [WR_W-1:0]    wr_word, wr_data;
  logic               wr_tgl, wr_stb;
  logic [PARAM_W-1:0] coef_q [NUM_COEF];
  logic               tx_bit, cs_idle;
  logic [TOT_W-1:0]   rd_frame;

  spi_cal_wr_rx #(.FRAME_W(WR_W)) u_wr (
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .wr_word(wr_word), .wr_tgl(wr_tgl)
  );

  spi_cal_tgl_sync #(.DATA_W(WR_W)) u_sync (
    .clk(clk), .rst(rst), .tgl_in(wr_tgl), .data_in(wr_word),
    .stb(wr_stb), .data_out(wr_data)
  );

  spi_cal_param_bank #(
    .CMD_W(CMD_W), .PARAM_W(PARAM_W),
    .A0_DEF(A0_DEF), .A1_DEF(A1_DEF), .FT_DEF(FT_DEF)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .conv_start(conv_start), .coef_q(coef_q)
  );

  spi_cal_rd_tx #(.TOT_W(TOT_W)) u_rd (
    .clk(clk), .rst(rst), .conv_done(conv_done),
    .res_word({temp_in, cnt_ptat, cnt_ctat}),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .tx_bit(tx_bit), .cs_idle(cs_idle), .rd_frame(rd_frame)
  );

  assign cal_a0    = coef_q[IDX_A0];
  assign cal_a1    = coef_q[IDX_A1];
  assign cal_ftrim = coef_q[IDX_FTRIM];
  assign spi_miso  = spi_cs_n ? 1'bz : tx_bit;
endmodule

// File: rtl/spi_cal_port_chk.sv
module spi_cal_port_chk #(
  parameter int                 TOT_W   = 44,
  parameter int                 TEMP_W  = 12,
  parameter int                 CNT_W   = 16,
  parameter int                 PARAM_W = 16,
  parameter logic [PARAM_W-1:0] A0_DEF  = 16'h4D50,
  parameter logic [PARAM_W-1:0] A1_DEF  = 16'h0FF9,
  parameter logic [PARAM_W-1:0] FT_DEF  = 16'h4894
) (
  input logic               clk,
  input logic               rst,
  input logic               conv_start,
  input logic               conv_done,
  input logic [TEMP_W-1:0]  temp_in,
  input logic [CNT_W-1:0]   cnt_ptat,
  input logic [CNT_W-1:0]   cnt_ctat,
  input logic [PARAM_W-1:0] cal_a0,
  input logic [PARAM_W-1:0] cal_a1,
  input logic [PARAM_W-1:0] cal_ftrim,
  input logic               cs_idle,
  input logic [TOT_W-1:0]   rd_frame
);
  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    rst |=> (cal_a0 == A0_DEF && cal_a1 == A1_DEF && cal_ftrim == FT_DEF))
    else $error("coefficients not at defaults after reset"); // R1

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !conv_start |=> ($stable(cal_a0) && $stable(cal_a1) && $stable(cal_ftrim)))
    else $error("coefficient changed without conversion start"); // R4

  AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !cs_idle |=> $stable(rd_frame))
    else $error("snapshot changed during transfer"); // R7

  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
    (conv_done && cs_idle) |=>
      rd_frame == {$past(temp_in), $past(cnt_ptat), $past(cnt_ctat)})
    else $error("snapshot does not match result inputs"); // R6
endmodule

bind spi_cal_port spi_cal_port_chk #(
  .TOT_W(TOT_W), .TEMP_W(TEMP_W), .CNT_W(CNT_W), .PARAM_W(PARAM_W),
  .A0_DEF(A0_DEF), .A1_DEF(A1_DEF), .FT_DEF(FT_DEF)
) u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
  .temp_in(temp_in), .cnt_ptat(cnt_ptat), .cnt_ctat(cnt_ctat),
  .cal_a0(cal_a0), .cal_a1(cal_a1), .cal_ftrim(cal_ftrim),
  .cs_idle(cs_idle), .rd_frame(rd_frame)
);

// File: tb/spi_cal_port_tb.sv
`timescale 1ns/1ps
module spi_cal_port_tb;
  localparam int H = 34;  // half serial-clock period, ns

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_start = 1'b0, conv_done = 1'b0;
  logic [11:0] temp_in = '0;
  logic [15:0] cnt_ptat = '0, cnt_ctat = '0;
  logic [15:0] cal_a0, cal_a1, cal_ftrim;
  logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  wire         spi_miso;

  pullup (spi_miso);

  always #4 clk = ~clk;

  spi_cal_port u_dut (
    .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
    .temp_in(temp_in), .cnt_ptat(cnt_ptat), .cnt_ctat(cnt_ctat),
    .cal_a0(cal_a0), .cal_a1(cal_a1), .cal_ftrim(cal_ftrim),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_pend [3];
  logic [15:0] exp_cur  [3];
  logic [43:0] exp_frame = '0;

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [43:0] pack(input logic [11:0] t, input logic [15:0] p, input logic [15:0] c);
    return {t, p, c};
  endfunction

  function automatic int coef_of(input logic [7:0] cmd);
    if (cmd >= 8'h01 && cmd <= 8'h03) return int'(cmd) - 1;
    return -1;
  endfunction

  task automatic spi_frame(input logic [47:0] tx, input int n, output logic [47:0] rx);
    rx = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    #H;
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = tx[i];
      #H; spi_sclk = 1'b1; rx = {rx[46:0], spi_miso};
      #H; spi_sclk = 1'b0;
    end
    #H; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_done(input logic [11:0] t, input logic [15:0] p, input logic [15:0] c);
    @(negedge clk);
    temp_in = t; cnt_ptat = p; cnt_ctat = c; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    for (int k = 0; k < 3; k++) exp_cur[k] = exp_pend[k];
  endtask

  task automatic check_coefs(input string req);
    check({req, " a0"},    {32'h0, cal_a0},    {32'h0, exp_cur[0]});
    check({req, " a1"},    {32'h0, cal_a1},    {32'h0, exp_cur[1]});
    check({req, " ftrim"}, {32'h0, cal_ftrim}, {32'h0, exp_cur[2]});
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [15:0] val, input int n);
    logic [47:0] rx;
    int ci;
    spi_frame({24'h0, cmd, val}, n, rx);
    ci = coef_of(cmd);
    if (n >= 24 && ci >= 0) exp_pend[ci] = val;
  endtask

  task automatic do_read(input string req);
    logic [47:0] rx;
    spi_frame('0, 44, rx);
    check(req, {4'h0, rx[43:0]}, {4'h0, exp_frame});
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    exp_pend[0] = 16'h4D50; exp_pend[1] = 16'h0FF9; exp_pend[2] = 16'h4894;
    for (int k = 0; k < 3; k++) exp_cur[k] = exp_pend[k];
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);

    // R1: reset defaults
    check_coefs("R1 reset default");
    // R8: idle line released (pull-up reads 1)
    check("R8 idle miso hi-z", {47'h0, spi_miso}, 48'h1);

    // R6: directed read, negative temperature -25.5 C = 0xE68
    pulse_done(12'hE68, 16'h1234, 16'hFEDC);
    exp_frame = pack(12'hE68, 16'h1234, 16'hFEDC);
    repeat (2) @(negedge clk);
    do_read("R6 directed frame");
    check("R8 idle after frame", {47'h0, spi_miso}, 48'h1);

    // R8: clocks past bit 44 read 0
    begin
      logic [47:0] rx;
      pulse_done(12'h190, 16'hFFFF, 16'h8001);
      exp_frame = pack(12'h190, 16'hFFFF, 16'h8001);
      spi_frame('0, 48, rx);
      check("R8 tail zeros", rx, {exp_frame, 4'h0});
    end

    // R6: random frames
    for (int i = 0; i < 8; i++) begin
      logic [11:0] t; logic [15:0] p, c;
      t = 12'($urandom); p = 16'($urandom); c = 16'($urandom);
      pulse_done(t, p, c);
      exp_frame = pack(t, p, c);
      do_read("R6 random frame");
    end

    // R7: conv_done during a transfer is dropped
    begin
      logic [47:0] rx;
      fork
        spi_frame('0, 44, rx);
        begin
          repeat (40) @(negedge clk);
          pulse_done(12'h7FF, 16'hAAAA, 16'h5555);
        end
      join
      check("R7 transfer not torn", {4'h0, rx[43:0]}, {4'h0, exp_frame});
      do_read("R7 busy pulse dropped");
      pulse_done(12'h7FF, 16'hAAAA, 16'h5555);
      exp_frame = pack(12'h7FF, 16'hAAAA, 16'h5555);
      do_read("R7 idle pulse latched");
    end

    // R2 / R4: directed writes to each coefficient
    do_write(8'h01, 16'h1111, 24);
    do_write(8'h02, 16'h2222, 24);
    do_write(8'h03, 16'h3333, 24);
    check_coefs("R4 no effect before start");
    pulse_start();
    check_coefs("R2 applied at start");

    // R3: unknown commands ignored
    do_write(8'h00, 16'hDEAD, 24);
    do_write(8'h04, 16'hBEEF, 24);
    do_write(8'hFF, 16'hCAFE, 24);
    pulse_start();
    check_coefs("R3 bad cmd ignored");

    // R5: short frame writes nothing
    do_write(8'h01, 16'h9999, 20);
    pulse_start();
    check_coefs("R5 short frame");

    // R2: bits past 24 ignored; R9: same frame also reads
    begin
      logic [47:0] rx;
      spi_frame({8'h02, 16'h4567, 24'hFFFFFF} >> 4, 44, rx);
      exp_pend[1] = 16'h4567;
      check("R9 read during write", {4'h0, rx[43:0]}, {4'h0, exp_frame});
      pulse_start();
      check_coefs("R2 R9 write in long frame");
    end

    // R2 / R3 / R4: random writes
    for (int i = 0; i < 10; i++) begin
      logic [7:0] cmd; logic [15:0] v;
      cmd = 8'($urandom_range(0, 5));
      v = 16'($urandom);
      do_write(cmd, v, 24);
      check_coefs("R4 random hold");
      pulse_start();
      check_coefs("R2 R3 random write");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule